// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the modem-control byte and the modem-status byte of a 16550-style serial port. It drives four modem control outputs from the control byte. Every clock it takes a snapshot of four modem input lines: carrier detect, ring indicator, data-set-ready and clear-to-send. Any change since the previous snapshot is recorded in a sticky change flag, and the flags raise a modem-status interrupt request when that interrupt is enabled.

In loopback mode the four input lines are not used. Their place is taken by the block's own control outputs, fed back internally: OUT2 to carrier detect, OUT1 to ring, DTR to data-set-ready and RTS to clear-to-send. A mode state machine with two states selects the source. In `MODE_PINS` the external lines are used. In `MODE_LOOP` the control lines are fed back. A control write with bit 4 set moves `MODE_PINS` to `MODE_LOOP`, and a control write with bit 4 clear moves `MODE_LOOP` back to `MODE_PINS`. Without such a write, each state holds. Reset enters `MODE_PINS`.

The read/write port has one address bit: 0 selects the control byte and 1 selects the status byte. Read data is combinational from the registers. A status read clears the change flags at the clock edge that ends the read. The modem input lines are expected to be already synchronized to `clk`.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset, a control read returns 0x08 (OUT2 set) and the status byte holds 0xB0: carrier, data-set-ready and clear-to-send set, and all change flags clear. `out2_o` is 1, the other control outputs are 0, and `irq_o` is 0.
- R2: A control write keeps wdata[4:0] and reads back with bits 7:5 zero. The outputs follow one clock after the write: DTR is bit 0, RTS is bit 1, OUT1 is bit 2, OUT2 is bit 3, and bit 4 is the loopback select.
- R3: Status bits 7:4 take the selected line values one clock after those values are presented: carrier on bit 7, ring on bit 6, data-set-ready on bit 5, clear-to-send on bit 4.
- R4: Status bits 3, 1 and 0 are set when carrier, data-set-ready and clear-to-send respectively differ from their previous snapshot. They stay set until a status read, even if the line returns to its old value.
- R5: Status bit 2 is set only when ring falls from 1 to 0. A rising ring line leaves it clear.
- R6: A status read returns the byte as it was before the read. At the edge that ends the read, bits 3:0 are cleared and bits 7:4 are kept.
- R7: A line change detected at the same edge as a status read is recorded after the clear, so its flag reads as set afterwards.
- R8: While bit 4 of the control byte is set, status bits 7:4 are OUT2, OUT1, DTR and RTS (in that order, from bit 7 down), and the external lines are ignored. Entering or leaving loopback takes effect on the status byte two clocks after the write.
- R9: `irq_o` is high exactly when `msi_en_i` is high and any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a status read clears the change flags |
| addr_i | input | 1 | 0 = control byte, 1 = status byte |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from the addressed register |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| dcd_i | input | 1 | Carrier detect line, active high, synchronized |
| ri_i | input | 1 | Ring indicator line, active high, synchronized |
| dsr_i | input | 1 | Data-set-ready line, active high, synchronized |
| cts_i | input | 1 | Clear-to-send line, active high, synchronized |
| dtr_o | output | 1 | DTR control output |
| rts_o | output | 1 | RTS control output |
| out1_o | output | 1 | General control output 1 |
| out2_o | output | 1 | General control output 2 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A wrong snapshot register or a wrong mode state shows as a wrong upper nibble on the next status read. It also shows as a spurious or missing change flag, which reaches `irq_o` in the same cycle when the interrupt is enabled. Ring edges are checked in both directions. The read-clear edge is combined with a simultaneous line change. Entering and leaving loopback are each checked at the second clock after the write, where a wrong cross-mapping or a stale state would first appear.

// File: rtl/modem_pkg.sv
package modem_pkg;
    localparam int CTL_W    = 5;
    localparam int LINE_W   = 4;
    localparam int LOOP_BIT = 4;
    localparam int STAT_W   = 2 * LINE_W;
    localparam logic [STAT_W-1:0] STAT_RST = 8'hB0;
    localparam logic [LINE_W-1:0] CTL_RST  = 4'b1000;

    typedef enum logic {
        MODE_PINS = 1'b0,
        MODE_LOOP = 1'b1
    } mode_e;

    // Status upper nibble, bit 7 down to bit 4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    // Control lines, bit 3 down to bit 0
    typedef struct packed {
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } cline_t;
endpackage

// File: rtl/mctl_fsm.sv
module mctl_fsm
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output mode_e            mode,
    output cline_t           lines
);
    mode_e  state_q, state_d;
    cline_t lines_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_PINS: if (ctl_wr && ctl_wdata[LOOP_BIT])  state_d = MODE_LOOP;
            MODE_LOOP: if (ctl_wr && !ctl_wdata[LOOP_BIT]) state_d = MODE_PINS;
            default:   state_d = MODE_PINS;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_PINS;
        else        state_q <= state_d;
    end

    // Control line register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lines_q <= CTL_RST;
        else if (ctl_wr) lines_q <= ctl_wdata[LINE_W-1:0];
    end

    // Outputs
    always_comb begin
        mode  = state_q;
        lines = lines_q;
    end

    // R2: a control write lands in the line register on the next cycle
    p_ctl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (lines == $past(ctl_wdata[LINE_W-1:0])));
    // R8: mode only changes through a control write
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(mode));
endmodule

// File: rtl/line_select.sv
module line_select
    import modem_pkg::*;
(
    input  mode_e  mode,
    input  cline_t lines,
    input  mline_t pins,
    output mline_t cur
);
    always_comb begin
        unique case (mode)
            MODE_PINS: cur = pins;
            MODE_LOOP: begin
                cur.dcd = lines.out2;
                cur.ri  = lines.out1;
                cur.dsr = lines.dtr;
                cur.cts = lines.rts;
            end
            default:   cur = pins;
        endcase
    end
endmodule

// File: rtl/delta_tracker.sv
module delta_tracker
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mline_t            cur,
    input  logic              rd_clr,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] st_q, st_d;
    logic [LINE_W-1:0] diff, dset, kept;

    always_comb begin
        diff = st_q[STAT_W-1:LINE_W] ^ cur;
        // bit 2 records only a ring fall: old ring 1, new ring 0
        dset = {diff[3], diff[2] & st_q[6], diff[1], diff[0]};
        kept = rd_clr ? '0 : st_q[LINE_W-1:0];
        st_d = {cur, kept | dset};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STAT_RST;
        else        st_q <= st_d;
    end

    assign stat = st_q;

    // R3: upper nibble is the previous cycle's selected lines
    p_upper_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q[STAT_W-1:LINE_W] == $past(cur)));
    // R5: trailing-ring flag rises only with a 1->0 ring step
    p_teri_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[2]) |-> ($past(st_q[6]) && !st_q[6]));
    // R6: a read with no line change leaves every flag clear
    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (cur == st_q[STAT_W-1:LINE_W])) |=> (st_q[LINE_W-1:0] == '0));
    // R4: without a read, set flags stay set
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((st_q[LINE_W-1:0] & $past(st_q[LINE_W-1:0])) == $past(st_q[LINE_W-1:0])));
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import modem_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              msi_en_i,
    input  logic              dcd_i,
    input  logic              ri_i,
    input  logic              dsr_i,
    input  logic              cts_i,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              out1_o,
    output logic              out2_o,
    output logic              irq_o
);
    localparam logic A_CTL  = 1'b0;
    localparam logic A_STAT = 1'b1;

    logic              ctl_wr, stat_rd;
    mode_e             mode;
    cline_t            lines;
    mline_t            pins, cur;
    logic [STAT_W-1:0] stat;
    logic [CTL_W-1:0]  ctl_rd;
    logic              unused_hi;

    assign ctl_wr    = wr_en_i && (addr_i == A_CTL);
    assign stat_rd   = rd_en_i && (addr_i == A_STAT);
    assign unused_hi = ^wdata_i[DATA_W-1:CTL_W];

    assign pins.dcd = dcd_i;
    assign pins.ri  = ri_i;
    assign pins.dsr = dsr_i;
    assign pins.cts = cts_i;

    mctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (wdata_i[CTL_W-1:0]),
        .mode      (mode),
        .lines     (lines)
    );

    line_select u_sel (
        .mode  (mode),
        .lines (lines),
        .pins  (pins),
        .cur   (cur)
    );

    delta_tracker u_dt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur    (cur),
        .rd_clr (stat_rd),
        .stat   (stat)
    );

    assign ctl_rd = {logic'(mode), lines};

    always_comb begin
        if (addr_i == A_STAT) rdata_o = DATA_W'(stat);
        else                  rdata_o = DATA_W'(ctl_rd);
    end

    assign dtr_o  = lines.dtr;
    assign rts_o  = lines.rts;
    assign out1_o = lines.out1;
    assign out2_o = lines.out2;
    assign irq_o  = msi_en_i && (|stat[LINE_W-1:0]);

    // R9: a clearing read with no new change drops the request
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (cur == stat[STAT_W-1:LINE_W])) |=> !irq_o);
    // R8: in loopback the status nibble mirrors the control lines
    p_loop_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOOP) |=> (stat[STAT_W-1:LINE_W] ==
            {$past(lines.out2), $past(lines.out1), $past(lines.dtr), $past(lines.rts)}));
    // R1: control outputs mirror the stored lines
    p_out_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (out2_o == $past(wdata_i[3]) && dtr_o == $past(wdata_i[0])));
endmodule

// File: tb/tb_modem_ctl_stat.sv
`timescale 1ns/1ps
module tb_modem_ctl_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       msi_en = 1'b0;
    logic       dcd = 1'b1, ri = 1'b0, dsr = 1'b1, cts = 1'b1;
    logic       dtr, rts, out1, out2, irq;
    int         n_run = 0, n_fail = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    modem_ctl_stat #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .msi_en_i(msi_en),
        .dcd_i(dcd), .ri_i(ri), .dsr_i(dsr), .cts_i(cts),
        .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        step();
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        addr = 1'b0; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 control reset", v, 8'h08);
        rd(1'b1, v); chk("R1 status reset", v, 8'hB0);
        chk("R1 outputs reset", {4'h0, out2, out1, rts, dtr}, 8'h08);
        chk("R1 irq reset", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_ctl_write();
        logic [7:0] v;
        wr(8'hE7);
        chk("R2 outputs", {4'h0, out2, out1, rts, dtr}, 8'h07);
        rd(1'b0, v); chk("R2 readback masks upper bits", v, 8'h07);
        wr(8'h08);
        chk("R2 outputs restored", {4'h0, out2, out1, rts, dtr}, 8'h08);
    endtask

    task automatic t_cts_change();
        logic [7:0] v;
        cts = 1'b0; step();
        #1 chk("R9 irq masked", {7'h0, irq}, 8'h00);
        msi_en = 1'b1;
        #1 chk("R9 irq enabled", {7'h0, irq}, 8'h01);
        rd(1'b1, v); chk("R3 R4 cts fall", v, 8'hA1);
        #1 chk("R9 irq after clear", {7'h0, irq}, 8'h00);
        rd(1'b1, v); chk("R6 flags cleared", v, 8'hA0);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        ri = 1'b1; step();
        rd(1'b1, v); chk("R5 ring rise no flag", v, 8'hE0);
        ri = 1'b0; step();
        rd(1'b1, v); chk("R5 ring fall flag", v, 8'hA4);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        dcd = 1'b0; step();
        dcd = 1'b1; step();
        rd(1'b1, v); chk("R4 carrier flag sticky", v, 8'hA8);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        dsr = 1'b0;
        rd(1'b1, v); chk("R6 read returns prior byte", v, 8'hA0);
        rd(1'b1, v); chk("R7 change kept over clear", v, 8'h82);
        rd(1'b1, v); chk("R6 cleared again", v, 8'h80);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        wr(8'h1D); step();
        rd(1'b1, v); chk("R8 loop entry mapping", v, 8'hE2);
        cts = 1'b1; dcd = 1'b0; step();
        rd(1'b1, v); chk("R8 pins ignored", v, 8'hE0);
        rd(1'b0, v); chk("R8 control shows loop bit", v, 8'h1D);
        wr(8'h19); step();
        rd(1'b1, v); chk("R5 R8 loop ring fall", v, 8'hA4);
        wr(8'h08); step();
        #1 chk("R9 irq on exit change", {7'h0, irq}, 8'h01);
        rd(1'b1, v); chk("R8 loop exit", v, 8'h1B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_write();
        t_cts_change();
        t_ring();
        t_sticky();
        t_same_cycle();
        t_loop();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule